// File: doc/BRIEF.md
# Auxiliary RAM Burst DMA Engine

This block copies data between a main-memory port and an auxiliary RAM port, one 32-byte line per step. Software sets it up through eight 16-bit registers: a main-memory address, an auxiliary-RAM address and a transfer length. Each of the three values is split across an upper and a lower register. The upper length register also carries the direction bit. Writing the lower length register starts the copy.

A shared control/status register shows a busy flag while a copy runs. It also holds a completion flag with its enable, a sticky flag for a start attempt made while busy, and two more event flags that other sources set. All flags in this register are cleared by writing 1. A separate mode register reports when the auxiliary RAM has come out of its power-up wait. Software polls it before the first transfer.

Both memory sides are line-wide ports with a one-cycle read latency. Each line is moved with one read cycle followed by one write cycle.

Top module: `aux_dma_engine`

## Requirements
- R1: After reset, the control register (index 0) reads 0, the mode register (index 1) reads 0, `irq` is 0, and no memory port is accessed.
- R2: Bit 0 of the mode register becomes 1 once READY_CYCLES cycles have passed after reset, and it stays 1 from then on.
- R3: Register index map: 2 = main address upper, 3 = main address lower, 4 = aux address upper, 5 = aux address lower, 6 = length upper, 7 = length lower. Upper address and length registers keep only bits [ADDR_W-17:0], and the other bits read 0. Lower registers keep only bits [15:5], and bits [4:0] read 0. Bit 15 of the length upper register is the direction bit and reads back as written.
- R4: A write to register 7 while idle starts a transfer. Bit 9 of the control register then reads 1 for exactly 2 cycles per 32-byte line.
- R5: With direction 0, line i of the transfer is read from main line (main address/32)+i and written to aux line (aux address/32)+i. No other line is written.
- R6: With direction 1, data moves from aux lines to main lines, using the same address stepping as R5.
- R7: At the clock edge where busy falls, bit 5 (completion) of the control register becomes 1.
- R8: `irq` equals completion bit 5 ANDed with enable bit 6 of the control register. Bit 6 is read/write.
- R9: Writing 1 to bit 5 clears the completion flag. Writing 0 to bit 5 leaves it unchanged.
- R10: A one-cycle pulse on `evt_a` sets bit 3 and a pulse on `evt_b` sets bit 7. Each bit is cleared by writing 1 to it and left unchanged by writing 0.
- R11: A write to register 7 while busy is ignored. Register 7 keeps its old value and the running transfer still moves its original number of lines. The write sets sticky bit 10, which is cleared by writing 1 to it.
- R12: A start whose length field (bits [ADDR_W-1:5]) is zero raises bit 5 at the same edge. Busy never reads 1 and no memory access occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| evt_a | input | 1 | Sets event flag bit 3 |
| evt_b | input | 1 | Sets event flag bit 7 |
| irq | output | 1 | Completion interrupt |
| mm_rd | output | 1 | Main memory line read |
| mm_wr | output | 1 | Main memory line write |
| mm_line | output | ADDR_W-5 | Main memory line index |
| mm_wdata | output | 256 | Main memory write line |
| mm_rdata | input | 256 | Main memory read line, one cycle after `mm_rd` |
| ar_rd | output | 1 | Aux RAM line read |
| ar_wr | output | 1 | Aux RAM line write |
| ar_line | output | ADDR_W-5 | Aux RAM line index |
| ar_wdata | output | 256 | Aux RAM write line |
| ar_rdata | input | 256 | Aux RAM read line, one cycle after `ar_rd` |

## Verification
The hardest case to reach is a second start request that arrives while a copy is running. Only a few cycles are open for it, and its effect has to show up as nothing changing. The stimulus starts a four-line copy and writes the lower length register again on the very next cycle, while busy is certainly high. The bench then reads back the register, the sticky flag and the count of memory writes. The zero-length start is driven with nonzero low bits, which shows that the sub-line bits take no part in the length.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RD   = 2'd1,
    S_WR   = 2'd2
  } seq_state_e;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_MODE = 3'd1;
  localparam logic [2:0] RA_MMH  = 3'd2;
  localparam logic [2:0] RA_MML  = 3'd3;
  localparam logic [2:0] RA_ARH  = 3'd4;
  localparam logic [2:0] RA_ARL  = 3'd5;
  localparam logic [2:0] RA_LNH  = 3'd6;
  localparam logic [2:0] RA_LNL  = 3'd7;

  localparam int B_EVA  = 3;
  localparam int B_DONE = 5;
  localparam int B_MASK = 6;
  localparam int B_EVB  = 7;
  localparam int B_BUSY = 9;
  localparam int B_ERR  = 10;
  localparam int B_DIR  = 15;
endpackage

// File: rtl/bm_rst_sync.sv
module bm_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_out = s2_q;
endmodule

// File: rtl/bm_ready_ctr.sv
module bm_ready_ctr #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rdy_q, rdy_d;

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (!rdy_q) begin
      if (cnt_q == CW'(CYCLES)) rdy_d = 1'b1;
      else                      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready = rdy_q;

  // R2: once ready, it never drops
  p_ready_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |=> rdy_q);
endmodule

// File: rtl/bm_regfile.sv
module bm_regfile
  import bm_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int OFS_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [2:0]              reg_addr,
  input  logic [15:0]             reg_wdata,
  output logic [15:0]             reg_rdata,
  input  logic                    evt_a,
  input  logic                    evt_b,
  input  logic                    ready,
  input  logic                    busy,
  input  logic                    seq_done,
  output logic                    irq,
  output logic                    start,
  output logic                    start_dir,
  output logic [ADDR_W-OFS_W-1:0] start_mm,
  output logic [ADDR_W-OFS_W-1:0] start_ar,
  output logic [ADDR_W-OFS_W-1:0] start_len
);
  localparam int HI_W = ADDR_W - 16;
  localparam int LO_W = 16 - OFS_W;

  logic [HI_W-1:0] mmh_q, mmh_d, arh_q, arh_d, lnh_q, lnh_d;
  logic [LO_W-1:0] mml_q, mml_d, arl_q, arl_d, lnl_q, lnl_d;
  logic            dir_q, dir_d, mask_q, mask_d, done_q, done_d;
  logic            eva_q, eva_d, evb_q, evb_d, err_q, err_d;

  logic ctrl_wr, lnl_wr, busy_hit;

  assign ctrl_wr  = reg_wr && (reg_addr == RA_CTRL);
  assign lnl_wr   = reg_wr && (reg_addr == RA_LNL);
  assign start    = lnl_wr && !busy;
  assign busy_hit = lnl_wr && busy;

  assign start_dir = dir_q;
  assign start_mm  = {mmh_q, mml_q};
  assign start_ar  = {arh_q, arl_q};
  assign start_len = {lnh_q, reg_wdata[15:OFS_W]};

  always_comb begin
    mmh_d  = mmh_q;
    mml_d  = mml_q;
    arh_d  = arh_q;
    arl_d  = arl_q;
    lnh_d  = lnh_q;
    lnl_d  = lnl_q;
    dir_d  = dir_q;
    mask_d = mask_q;
    if (reg_wr) begin
      case (reg_addr)
        RA_MMH: mmh_d = reg_wdata[HI_W-1:0];
        RA_MML: mml_d = reg_wdata[15:OFS_W];
        RA_ARH: arh_d = reg_wdata[HI_W-1:0];
        RA_ARL: arl_d = reg_wdata[15:OFS_W];
        RA_LNH: begin
          lnh_d = reg_wdata[HI_W-1:0];
          dir_d = reg_wdata[B_DIR];
        end
        RA_LNL: if (!busy) lnl_d = reg_wdata[15:OFS_W];
        RA_CTRL: mask_d = reg_wdata[B_MASK];
        default: ;
      endcase
    end
    done_d = seq_done | (done_q & ~(ctrl_wr & reg_wdata[B_DONE]));
    eva_d  = evt_a    | (eva_q  & ~(ctrl_wr & reg_wdata[B_EVA]));
    evb_d  = evt_b    | (evb_q  & ~(ctrl_wr & reg_wdata[B_EVB]));
    err_d  = busy_hit | (err_q  & ~(ctrl_wr & reg_wdata[B_ERR]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mmh_q  <= '0;
      mml_q  <= '0;
      arh_q  <= '0;
      arl_q  <= '0;
      lnh_q  <= '0;
      lnl_q  <= '0;
      dir_q  <= 1'b0;
      mask_q <= 1'b0;
      done_q <= 1'b0;
      eva_q  <= 1'b0;
      evb_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      mmh_q  <= mmh_d;
      mml_q  <= mml_d;
      arh_q  <= arh_d;
      arl_q  <= arl_d;
      lnh_q  <= lnh_d;
      lnl_q  <= lnl_d;
      dir_q  <= dir_d;
      mask_q <= mask_d;
      done_q <= done_d;
      eva_q  <= eva_d;
      evb_q  <= evb_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[B_EVA]  = eva_q;
        reg_rdata[B_DONE] = done_q;
        reg_rdata[B_MASK] = mask_q;
        reg_rdata[B_EVB]  = evb_q;
        reg_rdata[B_BUSY] = busy;
        reg_rdata[B_ERR]  = err_q;
      end
      RA_MODE: reg_rdata[0] = ready;
      RA_MMH:  reg_rdata = {{(16-HI_W){1'b0}}, mmh_q};
      RA_MML:  reg_rdata = {mml_q, {OFS_W{1'b0}}};
      RA_ARH:  reg_rdata = {{(16-HI_W){1'b0}}, arh_q};
      RA_ARL:  reg_rdata = {arl_q, {OFS_W{1'b0}}};
      RA_LNH:  reg_rdata = {dir_q, {(15-HI_W){1'b0}}, lnh_q};
      RA_LNL:  reg_rdata = {lnl_q, {OFS_W{1'b0}}};
      default: reg_rdata = '0;
    endcase
  end

  assign irq = done_q & mask_q;

  // R7: a finishing sequencer always leaves the completion flag set
  p_done_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> done_q);

  // R11: a start attempt while busy keeps the length and raises the error
  p_busy_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_hit |=> ($stable(lnl_q) && err_q));

  // R10: writing zero to an event bit keeps it set
  p_eva_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !reg_wdata[B_EVA] && eva_q) |=> eva_q);
endmodule

// File: rtl/bm_burst_seq.sv
module bm_burst_seq
  import bm_pkg::*;
#(
  parameter int LINE_W = 21,
  parameter int DATA_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_dir,
  input  logic [LINE_W-1:0] start_mm,
  input  logic [LINE_W-1:0] start_ar,
  input  logic [LINE_W-1:0] start_len,
  output logic              busy,
  output logic              seq_done,
  output logic              mm_rd,
  output logic              mm_wr,
  output logic [LINE_W-1:0] mm_line,
  output logic [DATA_W-1:0] mm_wdata,
  input  logic [DATA_W-1:0] mm_rdata,
  output logic              ar_rd,
  output logic              ar_wr,
  output logic [LINE_W-1:0] ar_line,
  output logic [DATA_W-1:0] ar_wdata,
  input  logic [DATA_W-1:0] ar_rdata
);
  seq_state_e        st_q, st_d;
  logic              dir_q, dir_d;
  logic [LINE_W-1:0] mm_q, mm_d, ar_q, ar_d, rem_q, rem_d;

  always_comb begin
    st_d     = st_q;
    dir_d    = dir_q;
    mm_d     = mm_q;
    ar_d     = ar_q;
    rem_d    = rem_q;
    seq_done = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          if (start_len == '0) begin
            seq_done = 1'b1;
          end else begin
            st_d  = S_RD;
            dir_d = start_dir;
            mm_d  = start_mm;
            ar_d  = start_ar;
            rem_d = start_len;
          end
        end
      end
      S_RD: st_d = S_WR;
      S_WR: begin
        mm_d  = mm_q + LINE_W'(1);
        ar_d  = ar_q + LINE_W'(1);
        rem_d = rem_q - LINE_W'(1);
        if (rem_q == LINE_W'(1)) begin
          st_d     = S_IDLE;
          seq_done = 1'b1;
        end else begin
          st_d = S_RD;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      dir_q <= 1'b0;
      mm_q  <= '0;
      ar_q  <= '0;
      rem_q <= '0;
    end else begin
      st_q  <= st_d;
      dir_q <= dir_d;
      mm_q  <= mm_d;
      ar_q  <= ar_d;
      rem_q <= rem_d;
    end
  end

  logic rd_ph, wr_ph;
  assign rd_ph = (st_q == S_RD);
  assign wr_ph = (st_q == S_WR);

  assign busy     = (st_q != S_IDLE);
  assign mm_rd    = rd_ph & ~dir_q;
  assign ar_rd    = rd_ph &  dir_q;
  assign mm_wr    = wr_ph &  dir_q;
  assign ar_wr    = wr_ph & ~dir_q;
  assign mm_line  = mm_q;
  assign ar_line  = ar_q;
  assign mm_wdata = ar_rdata;
  assign ar_wdata = mm_rdata;

  // R4: a nonzero start makes the engine busy on the next cycle
  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && start_len != '0) |=> busy);

  // R12: a zero-length start never makes the engine busy
  p_zero_len_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && start_len == '0) |=> !busy);

  // R5: every line read is followed by its write
  p_read_then_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_rd || ar_rd) |=> (mm_wr || ar_wr));

  // R4: the remaining count is never zero while a line is being moved
  p_rem_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem_q != '0));
endmodule

// File: rtl/aux_dma_engine.sv
module aux_dma_engine #(
  parameter int ADDR_W       = 26,
  parameter int BURST_BYTES  = 32,
  parameter int READY_CYCLES = 16,
  localparam int OFS_W  = $clog2(BURST_BYTES),
  localparam int LINE_W = ADDR_W - OFS_W,
  localparam int DATA_W = 8 * BURST_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              evt_a,
  input  logic              evt_b,
  output logic              irq,
  output logic              mm_rd,
  output logic              mm_wr,
  output logic [LINE_W-1:0] mm_line,
  output logic [DATA_W-1:0] mm_wdata,
  input  logic [DATA_W-1:0] mm_rdata,
  output logic              ar_rd,
  output logic              ar_wr,
  output logic [LINE_W-1:0] ar_line,
  output logic [DATA_W-1:0] ar_wdata,
  input  logic [DATA_W-1:0] ar_rdata
);
  logic              rst_n_s;
  logic              ready, busy, seq_done, start, start_dir;
  logic [LINE_W-1:0] start_mm, start_ar, start_len;

  bm_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  bm_ready_ctr #(.CYCLES(READY_CYCLES)) u_ready (
    .clk   (clk),
    .rst_n (rst_n_s),
    .ready (ready)
  );

  bm_regfile #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_a     (evt_a),
    .evt_b     (evt_b),
    .ready     (ready),
    .busy      (busy),
    .seq_done  (seq_done),
    .irq       (irq),
    .start     (start),
    .start_dir (start_dir),
    .start_mm  (start_mm),
    .start_ar  (start_ar),
    .start_len (start_len)
  );

  bm_burst_seq #(.LINE_W(LINE_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (start),
    .start_dir (start_dir),
    .start_mm  (start_mm),
    .start_ar  (start_ar),
    .start_len (start_len),
    .busy      (busy),
    .seq_done  (seq_done),
    .mm_rd     (mm_rd),
    .mm_wr     (mm_wr),
    .mm_line   (mm_line),
    .mm_wdata  (mm_wdata),
    .mm_rdata  (mm_rdata),
    .ar_rd     (ar_rd),
    .ar_wr     (ar_wr),
    .ar_line   (ar_line),
    .ar_wdata  (ar_wdata),
    .ar_rdata  (ar_rdata)
  );

  // R1: no memory traffic unless a transfer is running
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |-> !(mm_rd || mm_wr || ar_rd || ar_wr));
endmodule

// File: tb/aux_dma_engine_tb.sv
`timescale 1ns/1ps
module aux_dma_engine_tb;
  localparam int LW = 21;
  localparam int DW = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = 3'd0;
  logic [15:0]   reg_wdata = 16'd0;
  logic [15:0]   reg_rdata;
  logic          evt_a = 1'b0, evt_b = 1'b0, irq;
  logic          mm_rd, mm_wr, ar_rd, ar_wr;
  logic [LW-1:0] mm_line, ar_line;
  logic [DW-1:0] mm_wdata, ar_wdata;
  logic [DW-1:0] mm_rdata, ar_rdata;

  logic [DW-1:0] mm_mem [64];
  logic [DW-1:0] ar_mem [64];
  logic          fill = 1'b0;
  int            acc_cnt, wr_cnt;
  int            total = 0, bad = 0;
  bit            finished = 1'b0;

  always #10 clk = ~clk;

  aux_dma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_a(evt_a), .evt_b(evt_b),
    .irq(irq), .mm_rd(mm_rd), .mm_wr(mm_wr), .mm_line(mm_line),
    .mm_wdata(mm_wdata), .mm_rdata(mm_rdata), .ar_rd(ar_rd), .ar_wr(ar_wr),
    .ar_line(ar_line), .ar_wdata(ar_wdata), .ar_rdata(ar_rdata)
  );

  function automatic logic [DW-1:0] pat(input int side, input int idx);
    logic [31:0] w;
    w = 32'(side) * 32'h1000_0000 + 32'(idx) * 32'h0001_0101 + 32'h5A;
    return {8{w}};
  endfunction

  always @(posedge clk) begin
    if (fill) begin
      for (int i = 0; i < 64; i++) begin
        mm_mem[i] <= pat(0, i);
        ar_mem[i] <= pat(1, i);
      end
      acc_cnt <= 0;
      wr_cnt  <= 0;
    end else begin
      if (mm_rd) mm_rdata <= mm_mem[mm_line[5:0]];
      if (ar_rd) ar_rdata <= ar_mem[ar_line[5:0]];
      if (mm_wr) mm_mem[mm_line[5:0]] <= mm_wdata;
      if (ar_wr) ar_mem[ar_line[5:0]] <= ar_wdata;
      if (mm_rd || mm_wr || ar_rd || ar_wr) acc_cnt <= acc_cnt + 1;
      if (mm_wr || ar_wr) wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    logic [15:0] v;
    cyc = 0;
    rd_reg(3'd0, v);
    while (v[9] && cyc < 200) begin
      cyc++;
      @(negedge clk);
      rd_reg(3'd0, v);
    end
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd_reg(3'd0, v); check(v == 16'h0, "R1 ctrl after reset", 32'(v), 32'h0);
    rd_reg(3'd1, v); check(v == 16'h0, "R1 mode after reset", 32'(v), 32'h0);
    check(irq == 1'b0, "R1 irq after reset", 32'(irq), 32'h0);
    repeat (3) @(negedge clk);
    check(acc_cnt == 0, "R1 no access", 32'(acc_cnt), 32'h0);
  endtask

  task automatic t_ready;
    logic [15:0] v;
    repeat (40) @(negedge clk);
    rd_reg(3'd1, v); check(v == 16'h1, "R2 ready set", 32'(v), 32'h1);
    repeat (5) @(negedge clk);
    rd_reg(3'd1, v); check(v == 16'h1, "R2 ready stays", 32'(v), 32'h1);
  endtask

  task automatic t_fields;
    logic [15:0] v;
    wr_reg(3'd2, 16'hFFFF); rd_reg(3'd2, v);
    check(v == 16'h03FF, "R3 main upper mask", 32'(v), 32'h03FF);
    wr_reg(3'd3, 16'hFFFF); rd_reg(3'd3, v);
    check(v == 16'hFFE0, "R3 main lower mask", 32'(v), 32'hFFE0);
    wr_reg(3'd6, 16'hFFFF); rd_reg(3'd6, v);
    check(v == 16'h83FF, "R3 length upper with dir", 32'(v), 32'h83FF);
    wr_reg(3'd5, 16'h1234); rd_reg(3'd5, v);
    check(v == 16'h1220, "R3 aux lower mask", 32'(v), 32'h1220);
  endtask

  task automatic t_forward;
    logic [15:0] v;
    int cyc, w0;
    bit ok;
    w0 = wr_cnt;
    wr_reg(3'd2, 16'h0000); wr_reg(3'd3, 16'h0040);
    wr_reg(3'd4, 16'h0000); wr_reg(3'd5, 16'h0140);
    wr_reg(3'd6, 16'h0000); wr_reg(3'd7, 16'h0060);
    wait_idle(cyc);
    check(cyc == 6, "R4 busy cycles for 3 lines", 32'(cyc), 32'd6);
    rd_reg(3'd0, v);
    check(v[5] == 1'b1, "R7 done after forward", 32'(v), 32'h0020);
    ok = 1'b1;
    for (int i = 0; i < 3; i++) if (ar_mem[10+i] !== pat(0, 2+i)) ok = 1'b0;
    check(ok, "R5 aux lines 10..12 copied", 32'(ok), 32'h1);
    check(ar_mem[13] === pat(1, 13) && ar_mem[9] === pat(1, 9),
          "R5 neighbours untouched", 32'(ar_mem[13][31:0]), pat(1, 13)[31:0]);
    check(wr_cnt - w0 == 3, "R5 write count", 32'(wr_cnt - w0), 32'd3);
    check(irq == 1'b0, "R8 irq masked", 32'(irq), 32'h0);
    wr_reg(3'd0, 16'h0040);
    check(irq == 1'b1, "R8 irq enabled", 32'(irq), 32'h1);
    rd_reg(3'd0, v);
    check(v[5] == 1'b1, "R9 write 0 keeps done", 32'(v), 32'h0060);
    wr_reg(3'd0, 16'h0060);
    rd_reg(3'd0, v);
    check(v[5] == 1'b0 && v[6] == 1'b1, "R9 write 1 clears done", 32'(v), 32'h0040);
    check(irq == 1'b0, "R8 irq follows flag", 32'(irq), 32'h0);
    wr_reg(3'd0, 16'h0000);
  endtask

  task automatic t_reverse;
    logic [15:0] v;
    int cyc;
    wr_reg(3'd2, 16'h0000); wr_reg(3'd3, 16'h0280);
    wr_reg(3'd4, 16'h0000); wr_reg(3'd5, 16'h00A0);
    wr_reg(3'd6, 16'h8000); wr_reg(3'd7, 16'h0040);
    wait_idle(cyc);
    check(cyc == 4, "R4 busy cycles for 2 lines", 32'(cyc), 32'd4);
    check(mm_mem[20] === pat(1, 5) && mm_mem[21] === pat(1, 6),
          "R6 main lines 20..21 copied", 32'(mm_mem[20][31:0]), pat(1, 5)[31:0]);
    check(mm_mem[22] === pat(0, 22), "R6 main line 22 untouched",
          32'(mm_mem[22][31:0]), pat(0, 22)[31:0]);
    rd_reg(3'd0, v);
    check(v[5] == 1'b1, "R7 done after reverse", 32'(v), 32'h0020);
    wr_reg(3'd0, 16'h0020);
  endtask

  task automatic t_events;
    logic [15:0] v;
    @(negedge clk); evt_a = 1'b1; @(negedge clk); evt_a = 1'b0;
    @(negedge clk); evt_b = 1'b1; @(negedge clk); evt_b = 1'b0;
    rd_reg(3'd0, v);
    check(v[3] && v[7], "R10 events set", 32'(v), 32'h0088);
    wr_reg(3'd0, 16'h0000); rd_reg(3'd0, v);
    check(v[3] && v[7], "R10 write 0 keeps", 32'(v), 32'h0088);
    wr_reg(3'd0, 16'h0008); rd_reg(3'd0, v);
    check(!v[3] && v[7], "R10 clear bit 3 only", 32'(v), 32'h0080);
    wr_reg(3'd0, 16'h0080); rd_reg(3'd0, v);
    check(v == 16'h0, "R10 clear bit 7", 32'(v), 32'h0);
  endtask

  task automatic t_busy_start;
    logic [15:0] v;
    int cyc, w0;
    w0 = wr_cnt;
    wr_reg(3'd2, 16'h0000); wr_reg(3'd3, 16'h0000);
    wr_reg(3'd4, 16'h0000); wr_reg(3'd5, 16'h03C0);
    wr_reg(3'd6, 16'h0000); wr_reg(3'd7, 16'h0080);
    rd_reg(3'd0, v);
    check(v[9] == 1'b1, "R4 busy after start", 32'(v), 32'h0200);
    wr_reg(3'd7, 16'h0020);
    rd_reg(3'd7, v);
    check(v == 16'h0080, "R11 length low kept", 32'(v), 32'h0080);
    rd_reg(3'd0, v);
    check(v[10] == 1'b1, "R11 error set", 32'(v), 32'h0400);
    wait_idle(cyc);
    check(wr_cnt - w0 == 4, "R11 original line count", 32'(wr_cnt - w0), 32'd4);
    check(ar_mem[33] === pat(0, 3), "R11 last line copied",
          32'(ar_mem[33][31:0]), pat(0, 3)[31:0]);
    wr_reg(3'd0, 16'h0420); rd_reg(3'd0, v);
    check(v == 16'h0, "R11 error cleared", 32'(v), 32'h0);
  endtask

  task automatic t_zero;
    logic [15:0] v;
    int a0;
    a0 = acc_cnt;
    wr_reg(3'd6, 16'h0000); wr_reg(3'd7, 16'h001F);
    rd_reg(3'd0, v);
    check(v[9] == 1'b0, "R12 never busy", 32'(v), 32'h0020);
    check(v[5] == 1'b1, "R12 done raised", 32'(v), 32'h0020);
    repeat (4) @(negedge clk);
    check(acc_cnt == a0, "R12 no access", 32'(acc_cnt - a0), 32'h0);
    wr_reg(3'd0, 16'h0020);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    fill = 1'b1;
    repeat (3) @(negedge clk);
    fill = 1'b0;
    rst_n = 1'b1;
    t_reset;
    t_ready;
    t_fields;
    t_forward;
    t_reverse;
    t_events;
    t_busy_start;
    t_zero;
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule